// File: doc/BRIEF.md
# SPI Serial Bit-Clock Generator

This block makes the serial bit clock for an SPI-style port that can run as master or as slave. In master mode it picks one of two internal clock-enable ticks, an auxiliary tick or a subsystem tick, and divides it by a 16-bit factor. The result drives the serial clock output, and a one-cycle strobe marks each rising and falling edge. In slave mode the divider is bypassed and the synchronized serial clock from outside is passed through to the same output. The source select and the divisor have no effect in that mode.

The division factor is loaded as two byte registers, an upper and a lower one. Any change of mode, or of select or divisor while in master mode, restarts the divider from its idle low level. The block raises a one-cycle error flag when the external source is selected in master mode. While that illegal pairing lasts, it generates no clock edges.

Top module: `spi_bitclk_gen`

## Requirements
- R1: In master mode the source select picks the tick that advances the divider: 2'b01 the auxiliary tick, 2'b10 and 2'b11 both the subsystem tick.
- R2: In slave mode (`master_i`=0) `sclk_o` equals `ext_sclk_i` sampled one clock earlier. The source select and both divisor bytes have no effect on it.
- R3: The division factor is {`div_hi_i`,`div_lo_i`} (high byte in bits 15:8). In master mode one `sclk_o` period spans that many selected ticks.
- R4: A division factor of 0 or 1 behaves as 2, so the fastest master bit clock is half the selected tick rate.
- R5: For a factor N, `sclk_o` stays low for ceil(N/2) selected ticks after a falling edge or reload, then high for floor(N/2) ticks.
- R6: `rise_o` (`fall_o`) is high for exactly the one cycle in which `sclk_o` has just gone from 0 to 1 (1 to 0). The two strobes are never high together.
- R7: A change of mode, or of select or divisor while in master mode, drives `sclk_o` low in the next cycle with no strobe, and restarts the low phase. Any tick seen in the change cycle is dropped.
- R8: When the configuration changes into master mode with select 2'b00, `cfg_err_o` pulses for one cycle. While that pairing holds, no strobes occur and `sclk_o` stays low.
- R9: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aux_tick_i | input | 1 | Auxiliary clock-enable tick |
| sub_tick_i | input | 1 | Subsystem clock-enable tick |
| ext_sclk_i | input | 1 | Synchronized external serial clock level |
| master_i | input | 1 | 1 = master, 0 = slave |
| src_sel_i | input | 2 | Clock source select |
| div_hi_i | input | 8 | Division factor, upper byte |
| div_lo_i | input | 8 | Division factor, lower byte |
| sclk_o | output | 1 | Serial bit clock |
| rise_o | output | 1 | Rising-edge strobe |
| fall_o | output | 1 | Falling-edge strobe |
| cfg_err_o | output | 1 | Illegal source/mode pulse |

## Verification
The assertions assume that `ext_sclk_i` is already synchronized to `clk` and that configuration inputs change only between clock edges. The bench drives every input on the falling edge, so both conditions hold by construction. The ticks are random single-cycle enables, and the properties make no assumption about their density. Configuration changes are spaced by runs of at least several cycles, so the reload, error-pulse and slave-follow properties each get stable windows in which to apply.

// File: rtl/spi_bclk_pkg.sv
package spi_bclk_pkg;
    localparam int BYTE_W = 8;
    localparam int DIV_W  = 2 * BYTE_W;
    localparam int MIN_DIV = 2;

    typedef enum logic [1:0] {
        SRC_EXT     = 2'b00,
        SRC_AUX     = 2'b01,
        SRC_SUB     = 2'b10,
        SRC_SUB_ALT = 2'b11
    } src_sel_e;

    typedef struct packed {
        logic             master;
        logic [1:0]       sel;
        logic [DIV_W-1:0] div;
    } bclk_cfg_t;

    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] raw);
        return (raw < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : raw;
    endfunction

    function automatic logic cfg_illegal(input bclk_cfg_t c);
        return c.master && (c.sel == SRC_EXT);
    endfunction
endpackage

// File: rtl/bclk_cfg_track.sv
module bclk_cfg_track
    import spi_bclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  bclk_cfg_t cfg_in,
    output bclk_cfg_t cfg_q,
    output logic      reload,
    output logic      err_pulse
);
    typedef struct packed {
        bclk_cfg_t cfg;
        logic      err;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        reload = (cfg_in.master != st_q.cfg.master) ||
                 (cfg_in.master && ((cfg_in.sel != st_q.cfg.sel) ||
                                    (cfg_in.div != st_q.cfg.div)));
        st_d.cfg = cfg_in;
        st_d.err = reload && cfg_illegal(cfg_in) && !cfg_illegal(st_q.cfg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_q     = st_q.cfg;
    assign err_pulse = st_q.err;
endmodule

// File: rtl/bclk_src_sel.sv
module bclk_src_sel
    import spi_bclk_pkg::*;
(
    input  bclk_cfg_t cfg,
    input  logic      aux_tick,
    input  logic      sub_tick,
    output logic      tick,
    output logic      illegal
);
    always_comb begin
        illegal = cfg_illegal(cfg);
        unique case (src_sel_e'(cfg.sel))
            SRC_AUX:             tick = aux_tick;
            SRC_SUB, SRC_SUB_ALT: tick = sub_tick;
            default:             tick = 1'b0;
        endcase
        if (!cfg.master) tick = 1'b0;
    end
endmodule

// File: rtl/bclk_div_core.sv
module bclk_div_core #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reload,
    input  logic [DIV_W-1:0] div_n,
    output logic             sclk,
    output logic             rise,
    output logic             fall
);
    localparam int CNT_W = DIV_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sclk;
        logic             rise;
        logic             fall;
    } core_t;

    core_t st_d, st_q;
    logic [CNT_W-1:0] low_len;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        low_len  = (CNT_W'(div_n) + CNT_W'(1)) >> 1;
        last_cnt = CNT_W'(div_n) - CNT_W'(1);
        st_d      = st_q;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        if (reload) begin
            st_d.cnt  = '0;
            st_d.sclk = 1'b0;
        end else if (tick) begin
            if (st_q.cnt >= last_cnt) begin
                st_d.cnt  = '0;
                st_d.sclk = 1'b0;
                st_d.fall = st_q.sclk;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
                if (st_d.cnt == low_len) begin
                    st_d.sclk = 1'b1;
                    st_d.rise = !st_q.sclk;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sclk = st_q.sclk;
    assign rise = st_q.rise;
    assign fall = st_q.fall;
endmodule

// File: rtl/spi_bitclk_gen.sv
module spi_bitclk_gen
    import spi_bclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aux_tick_i,
    input  logic              sub_tick_i,
    input  logic              ext_sclk_i,
    input  logic              master_i,
    input  logic [1:0]        src_sel_i,
    input  logic [BYTE_W-1:0] div_hi_i,
    input  logic [BYTE_W-1:0] div_lo_i,
    output logic              sclk_o,
    output logic              rise_o,
    output logic              fall_o,
    output logic              cfg_err_o
);
    typedef struct packed {
        logic sclk;
        logic rise;
        logic fall;
    } slv_t;

    bclk_cfg_t cfg_in, cfg_q;
    logic reload, err_pulse, sel_tick, illegal_q, core_tick;
    logic m_sclk, m_rise, m_fall;
    slv_t slv_d, slv_q;

    assign cfg_in.master = master_i;
    assign cfg_in.sel    = src_sel_i;
    assign cfg_in.div    = {div_hi_i, div_lo_i};

    bclk_cfg_track u_trk (
        .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in),
        .cfg_q(cfg_q), .reload(reload), .err_pulse(err_pulse)
    );

    bclk_src_sel u_sel (
        .cfg(cfg_q), .aux_tick(aux_tick_i), .sub_tick(sub_tick_i),
        .tick(sel_tick), .illegal(illegal_q)
    );

    assign core_tick = sel_tick && !illegal_q;

    bclk_div_core #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .tick(core_tick), .reload(reload),
        .div_n(clamp_div(cfg_q.div)),
        .sclk(m_sclk), .rise(m_rise), .fall(m_fall)
    );

    always_comb begin
        slv_d = '0;
        if (!reload) begin
            slv_d.sclk = ext_sclk_i;
            slv_d.rise = ext_sclk_i && !slv_q.sclk;
            slv_d.fall = !ext_sclk_i && slv_q.sclk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slv_q <= '0;
        else        slv_q <= slv_d;
    end

    assign sclk_o    = cfg_q.master ? m_sclk : slv_q.sclk;
    assign rise_o    = cfg_q.master ? m_rise : slv_q.rise;
    assign fall_o    = cfg_q.master ? m_fall : slv_q.fall;
    assign cfg_err_o = err_pulse;
endmodule

// File: rtl/spi_bitclk_gen_chk.sv
module spi_bitclk_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ext_sclk_i,
    input logic       master_i,
    input logic [1:0] src_sel_i,
    input logic       sclk_o,
    input logic       rise_o,
    input logic       fall_o,
    input logic       cfg_err_o
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_o && fall_o)); // R6
    AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> (sclk_o && !$past(sclk_o))); // R6
    AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> (!sclk_o && $past(sclk_o))); // R6
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> !cfg_err_o); // R8
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && src_sel_i == 2'b00 && $past(master_i && src_sel_i == 2'b00))
        |=> (!rise_o && !fall_o && !sclk_o)); // R8
    AST_SLAVE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_i && $past(!master_i)) |=> (sclk_o == $past(ext_sclk_i))); // R2
    AST_MODE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i != $past(master_i)) |=> (!sclk_o && !rise_o && !fall_o)); // R7
endmodule

bind spi_bitclk_gen spi_bitclk_gen_chk i_chk (
    .clk(clk), .rst_n(rst_n), .ext_sclk_i(ext_sclk_i), .master_i(master_i),
    .src_sel_i(src_sel_i), .sclk_o(sclk_o), .rise_o(rise_o), .fall_o(fall_o),
    .cfg_err_o(cfg_err_o)
);

// File: tb/test_spi_bitclk_gen.sv
module test_spi_bitclk_gen;
    logic clk = 0, rst_n = 0;
    logic aux_tick_i = 0, sub_tick_i = 0, ext_sclk_i = 0, master_i = 0;
    logic [1:0] src_sel_i = 0;
    logic [7:0] div_hi_i = 0, div_lo_i = 0;
    logic sclk_o, rise_o, fall_o, cfg_err_o;

    int n_run = 0, n_fail = 0;
    string req = "R9";
    bit done = 0;

    always #5 clk = ~clk;

    spi_bitclk_gen i_spi_bitclk_gen (.*);

    // behavioural reference
    int pm = 0, ps = 0, pd = 0, cnt = 0;
    bit msclk = 0, mr = 0, mf = 0, slv = 0, sr = 0, sf = 0, eerr = 0;
    bit e_sclk = 0, e_rise = 0, e_fall = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pm = 0; ps = 0; pd = 0; cnt = 0;
            msclk = 0; mr = 0; mf = 0; slv = 0; sr = 0; sf = 0; eerr = 0;
        end else begin
            int m, s, d, n, lo;
            bit rl, tk, ill_old;
            m = master_i; s = src_sel_i; d = {div_hi_i, div_lo_i};
            rl = (m != pm) || (m == 1 && (s != ps || d != pd));
            ill_old = (pm == 1 && ps == 0);
            eerr = rl && m == 1 && s == 0 && !ill_old;
            n = (pd < 2) ? 2 : pd;
            lo = (n + 1) / 2;
            tk = !rl && pm == 1 && ((ps == 1 && aux_tick_i) || (ps >= 2 && sub_tick_i));
            mr = 0; mf = 0;
            if (rl) begin cnt = 0; msclk = 0; end
            else if (tk) begin
                if (cnt == n - 1) begin cnt = 0; mf = msclk; msclk = 0; end
                else begin cnt++; if (cnt == lo) begin mr = !msclk; msclk = 1; end end
            end
            if (rl) begin sr = 0; sf = 0; slv = 0; end
            else begin sr = ext_sclk_i && !slv; sf = !ext_sclk_i && slv; slv = ext_sclk_i; end
            pm = m; ps = s; pd = d;
        end
        e_sclk = pm ? msclk : slv;
        e_rise = pm ? mr : sr;
        e_fall = pm ? mf : sf;
    end

    task automatic chk(input string r, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", r, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (!done) begin
        chk(req, "sclk_o", sclk_o, e_sclk);
        chk("R6", "rise_o", rise_o, e_rise);
        chk("R6", "fall_o", fall_o, e_fall);
        chk("R8", "cfg_err_o", cfg_err_o, eerr);
    end

    task automatic setcfg(input logic m, input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        master_i = m; src_sel_i = s; {div_hi_i, div_lo_i} = d;
    endtask

    task automatic run(input int cycles, input bit wiggle_cfg);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            aux_tick_i = 1'($urandom);
            sub_tick_i = 1'($urandom);
            if ((i % 3) == 0) ext_sclk_i = 1'($urandom);
            if (wiggle_cfg) begin
                src_sel_i = 2'($urandom);
                {div_hi_i, div_lo_i} = 16'($urandom);
            end
        end
    endtask

    initial begin
        master_i = 1; src_sel_i = 2'b01;
        repeat (3) @(negedge clk);
        req = "R9";
        chk("R9", "reset sclk_o", sclk_o, 1'b0);
        chk("R9", "reset rise_o", rise_o, 1'b0);
        chk("R9", "reset err", cfg_err_o, 1'b0);
        rst_n = 1;
        req = "R1"; setcfg(1, 2'b01, 16'd4); run(300, 0);
        setcfg(1, 2'b10, 16'd4); run(300, 0);
        setcfg(1, 2'b11, 16'd6); run(300, 0);
        req = "R3"; setcfg(1, 2'b10, 16'h0105); run(1500, 0);
        setcfg(1, 2'b01, 16'd10); run(400, 0);
        req = "R4"; setcfg(1, 2'b10, 16'd0); run(200, 0);
        setcfg(1, 2'b10, 16'd1); run(200, 0);
        req = "R5"; setcfg(1, 2'b11, 16'd7); run(400, 0);
        setcfg(1, 2'b01, 16'd3); run(400, 0);
        req = "R2"; setcfg(0, 2'b01, 16'd9); run(600, 1);
        req = "R7";
        for (int k = 0; k < 40; k++) begin
            setcfg(1'($urandom_range(0, 3) != 0), 2'($urandom_range(1, 3)),
                   16'($urandom_range(0, 9)));
            run(8 + (k % 13), 0);
        end
        req = "R8"; setcfg(1, 2'b00, 16'd4); run(200, 0);
        setcfg(1, 2'b01, 16'd4); run(50, 0);
        setcfg(1, 2'b00, 16'd5); run(20, 0);
        setcfg(1, 2'b00, 16'd8); run(50, 0);
        setcfg(0, 2'b00, 16'd8); run(100, 0);
        setcfg(1, 2'b00, 16'd2); run(50, 0);
        @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(150000 * 10);
        done = 1;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule